// File: doc/BRIEF.md
# Memory Select Guard with Brown-out Grace Window

This block sits between a processor and a memory. It takes the processor's active-low chip select and drives an active-low select to the memory. While the supply is good and the supervisor holds no reset, the select passes straight through with no register in the path. When the supervisor signals a fault, further selects are refused, so no write can land in the memory while the supply is out of tolerance. A fault is either the supervisor's reset flag going high or its supply-OK flag going low.

A select that is already active when the fault arrives is not cut off at once. It keeps its low level for a bounded number of tick pulses, so an access in flight can complete. The window closes early if the processor releases the select first. After the window closes, the memory select stays high until the fault clears. The tick enable sets the time base. With a 1 µs tick, the default of 15 ticks gives a window of about 15 µs.

Top module: `memsel_guard`

## Requirements
- R1: Whenever `sel_in_n` is high, `sel_out_n` is high in the same cycle, in every state.
- R2: With no fault and no initialisation pending, `sel_out_n` equals `sel_in_n` in the same cycle, combinationally.
- R3: In the cycle a fault first appears, if `sel_in_n` is low, `sel_out_n` stays low and a grace window starts.
- R4: A grace window counts `tick` pulses from the cycle after it starts. The window closes at the clock edge that samples the `GRACE_TICKS`-th counted pulse. From the next cycle, `sel_out_n` is high while the fault lasts.
- R5: A grace window closes early when `sel_in_n` goes high. The output is high in that same cycle.
- R6: After a window closes early, `sel_out_n` stays high while the fault lasts, even if `sel_in_n` goes low again.
- R7: If `sel_in_n` is high in the cycle a fault first appears, no window is granted. `sel_out_n` stays high while the fault lasts.
- R8: A fault is `sup_reset` = 1 or `supply_ok` = 0. Either condition alone starts the fault behaviour.
- R9: An edge that samples `rst_n` low puts the block in an initial state and clears the grace counter. In that state `sel_out_n` is high. The block leaves that state at the first edge that samples `rst_n` high. It goes to the blocking state if a fault is present there, with no window granted.
- R10: Once the fault clears, whether during a grace window or during blocking, `sel_out_n` follows `sel_in_n` again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low initialisation |
| tick | input | 1 | One-cycle time-base pulse for the grace window |
| sel_in_n | input | 1 | Active-low select from the processor |
| supply_ok | input | 1 | Supervisor flag: supply above the threshold |
| sup_reset | input | 1 | Supervisor reset state, active high |
| sel_out_n | output | 1 | Gated active-low select to the memory |

## Verification
A fault can arrive in the same cycle as the processor's select changes level. That cycle decides between a grace window (R3) and an immediate block (R7). The end of a window can also fall on the same cycle as a tick that would expire it, or as the fault clearing. The bench provokes these collisions with directed sequences and with random stimulus in which fault flags, select and tick all change on the same cycles. Each cycle's output is judged against a reference model built from the requirements, which knows only the mode and the tick count.

// File: rtl/memsel_guard_pkg.sv
// Shared types for the memory select guard.
package memsel_guard_pkg;

    // Operating mode of the guard.
    typedef enum logic [1:0] {
        GM_INIT  = 2'd0,  // initialisation held or just released
        GM_FREE  = 2'd1,  // no fault seen: pass-through
        GM_GRACE = 2'd2,  // fault with an access in flight
        GM_HELD  = 2'd3   // fault: selects refused
    } guard_mode_e;

endpackage

// File: rtl/memsel_grace_timer.sv
// Grace window tick counter.
// Counts tick pulses while run is high and flags the pulse that closes the
// window. Assumes GRACE_TICKS >= 1 and that run drops the cycle after expire.
module memsel_grace_timer #(
    parameter int GRACE_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (GRACE_TICKS < 2) ? 1 : $clog2(GRACE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(GRACE_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks inside a window; clear outside one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The window closes on the tick that finds the count at its last value.
    always_comb begin
        expire = run && tick && (cnt_q == LAST);
    end

endmodule

// File: rtl/memsel_mode_fsm.sv
// Mode register of the guard.
// Moves between pass-through, grace and blocking from the fault flag, the
// input select and the timer expiry. Assumes a fault is already combined.
module memsel_mode_fsm
    import memsel_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fault,
    input  logic        sel_in_n,
    input  logic        expire,
    output guard_mode_e mode
);
    guard_mode_e mode_q;
    guard_mode_e mode_d;

    // Next-mode decision.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            GM_INIT:  mode_d = fault ? GM_HELD : GM_FREE;
            GM_FREE: begin
                if (fault) begin
                    mode_d = sel_in_n ? GM_HELD : GM_GRACE;
                end
            end
            GM_GRACE: begin
                if (!fault) begin
                    mode_d = GM_FREE;
                end else if (sel_in_n || expire) begin
                    mode_d = GM_HELD;
                end
            end
            GM_HELD: begin
                if (!fault) begin
                    mode_d = GM_FREE;
                end
            end
            default:  mode_d = GM_INIT;
        endcase
    end

    // Mode register with synchronous initialisation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= GM_INIT;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/memsel_out_gate.sv
// Output gate of the guard.
// Combinational: a select passes unless the block is initialising or
// blocking during a fault. Assumes mode comes from a register.
module memsel_out_gate
    import memsel_guard_pkg::*;
(
    input  guard_mode_e mode,
    input  logic        fault,
    input  logic        sel_in_n,
    output logic        sel_out_n
);
    // Force high when initialising or blocking; otherwise pass through.
    always_comb begin
        unique case (mode)
            GM_INIT:  sel_out_n = 1'b1;
            GM_HELD:  sel_out_n = fault | sel_in_n;
            default:  sel_out_n = sel_in_n;
        endcase
    end

endmodule

// File: rtl/memsel_guard.sv
// Memory select guard, top level.
// Passes the active-low select while the supply is good, grants a bounded
// grace window to an access in flight when a fault appears, then refuses
// selects until the fault clears. Assumes tick is a one-cycle pulse.
module memsel_guard
    import memsel_guard_pkg::*;
#(
    parameter int GRACE_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sel_in_n,
    input  logic supply_ok,
    input  logic sup_reset,
    output logic sel_out_n
);
    logic        fault;
    logic        expire;
    guard_mode_e mode;

    // Either supervisor flag raises a fault.
    always_comb begin
        fault = sup_reset | ~supply_ok;
    end

    memsel_grace_timer #(
        .GRACE_TICKS(GRACE_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (mode == GM_GRACE),
        .tick   (tick),
        .expire (expire)
    );

    memsel_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (fault),
        .sel_in_n (sel_in_n),
        .expire   (expire),
        .mode     (mode)
    );

    memsel_out_gate u_gate (
        .mode      (mode),
        .fault     (fault),
        .sel_in_n  (sel_in_n),
        .sel_out_n (sel_out_n)
    );

endmodule

// File: rtl/memsel_guard_chk.sv
// Property checker for the memory select guard, attached by bind.
// Observes ports only; keeps its own count of ticks spent low in a fault.
module memsel_guard_chk #(
    parameter int GRACE_TICKS = 15
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic sel_in_n,
    input logic supply_ok,
    input logic sup_reset,
    input logic sel_out_n
);
    localparam int RW = $clog2(GRACE_TICKS + 3);

    logic          fault;
    logic [RW-1:0] low_ticks;

    always_comb begin
        fault = sup_reset | ~supply_ok;
    end

    // Ticks seen while the output is low during a fault.
    always_ff @(posedge clk) begin
        if (!rst_n || !fault || sel_out_n) begin
            low_ticks <= '0;
        end else if (tick && (low_ticks != '1)) begin
            low_ticks <= low_ticks + 1'b1;
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sel_in_n |-> sel_out_n); // R1

    AST_LOW_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_out_n |-> !sel_in_n); // R1

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fault) && !fault) |-> (sel_out_n == sel_in_n)); // R2

    AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks <= RW'(GRACE_TICKS + 1)); // R4

    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault) && fault && $past(sel_out_n)) |-> sel_out_n); // R6

    AST_NO_GRACE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault) && sel_in_n) |=> (fault |-> sel_out_n)); // R7

    AST_INIT_HIGH: assert property (@(posedge clk)
        !rst_n |=> sel_out_n); // R9

endmodule

bind memsel_guard memsel_guard_chk #(
    .GRACE_TICKS(GRACE_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sel_in_n  (sel_in_n),
    .supply_ok (supply_ok),
    .sup_reset (sup_reset),
    .sel_out_n (sel_out_n)
);

// File: tb/memsel_guard_test.sv
// Bench for the memory select guard: directed corners plus seeded random.
module memsel_guard_test;
    localparam int G = 6;
    localparam int M_INIT = 0, M_FREE = 1, M_GRACE = 2, M_HELD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sel_in_n = 1'b1;
    logic supply_ok = 1'b1;
    logic sup_reset = 1'b0;
    logic sel_out_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state, from the requirements.
    int    m_mode = M_INIT;
    int    m_cnt = 0;
    string m_why = "R9";

    always #2 clk = ~clk;

    memsel_guard #(.GRACE_TICKS(G)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel_in_n(sel_in_n),
        .supply_ok(supply_ok), .sup_reset(sup_reset), .sel_out_n(sel_out_n)
    );

    function automatic logic exp_out(int mode, logic flt, logic in_n);
        if (mode == M_INIT) return 1'b1;
        if (mode == M_HELD) return flt | in_n;
        return in_n;
    endfunction

    function automatic string auto_tag(int mode, logic flt, logic in_n, string why);
        if (in_n) return "R1";
        if (mode == M_INIT) return "R9";
        if (!flt) return (mode == M_FREE) ? "R2" : "R10";
        if (mode == M_FREE) return "R3";
        if (mode == M_GRACE) return "R4";
        return why;
    endfunction

    // Drive one cycle, check the output, advance the model past the edge.
    task automatic step(input logic i_n, input logic ok, input logic rs,
                        input logic tk, input logic rn, input string tag);
        logic flt;
        logic e;
        string t;
        sel_in_n = i_n; supply_ok = ok; sup_reset = rs; tick = tk; rst_n = rn;
        #1;
        flt = rs | ~ok;
        e = exp_out(m_mode, flt, i_n);
        t = (tag != "") ? tag : auto_tag(m_mode, flt, i_n, m_why);
        checks++;
        if (sel_out_n !== e) begin
            failures++;
            $display("FAIL %s: sel_out_n=%b expected=%b (t=%0t)", t, sel_out_n, e, $time);
        end
        if (!rn) begin
            m_mode = M_INIT; m_cnt = 0; m_why = "R9";
        end else begin
            case (m_mode)
                M_INIT: begin
                    m_mode = flt ? M_HELD : M_FREE; m_why = "R9";
                end
                M_FREE: if (flt) begin
                    if (i_n) begin m_mode = M_HELD; m_why = "R7"; end
                    else begin m_mode = M_GRACE; m_cnt = 0; end
                end
                M_GRACE: begin
                    if (!flt) m_mode = M_FREE;
                    else if (i_n) begin m_mode = M_HELD; m_why = "R6"; end
                    else if (tk) begin
                        if (m_cnt == G - 1) begin m_mode = M_HELD; m_why = "R4"; end
                        else m_cnt++;
                    end
                end
                default: if (!flt) m_mode = M_FREE;
            endcase
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        logic i_n, ok, rs, rn;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        // R9: initialisation holds the output high.
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
        // R2: pass-through, both levels.
        for (int k = 0; k < 4; k++) step(k[0], 1'b1, 1'b0, 1'b0, 1'b1, "");
        // R3, R4: full grace window then blocking, with a re-select refused.
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        for (int k = 0; k < G + 3; k++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
        // R10: fault clears after blocking.
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        // R5, R6: early end by release, then re-select refused.
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R3");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R4");
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        // R7: idle select at fault onset.
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        // R8: supply_ok low alone, grace then block.
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        for (int k = 0; k < G + 1; k++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        // R10: fault clears mid-grace; R4: no ticks keeps window open.
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
        for (int k = 0; k < 20; k++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
        // R9: release into a present fault grants no window.
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        // Random mix of collisions.
        i_n = 1'b1; ok = 1'b1; rs = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 4 == 0) i_n = ~i_n;
            if ($urandom % 23 == 0) rs = ~rs;
            if ($urandom % 31 == 0) ok = ~ok;
            rn = ($urandom % 600 != 0);
            step(i_n, ok, rs, ($urandom % 3 == 0), rn, "");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule